// File: doc/BRIEF.md
# Dual-Edge Gated Frequency Counter

This block measures the frequency of a divided oscillator clock for a calibration controller. The counted clock is the oscillator output after a fixed divide-by-4. A start pulse in the reference domain opens a gate that lasts 2P reference cycles, which is 32 cycles with the default P = 16. During that window, two counters count the divided clock. One runs on the rising edges and the other on the falling edges, which it sees through an inverted copy of the clock.

When the window closes, the two partial counts are brought back into the reference domain and added. The sum is presented on `count` with a one-cycle `count_vld` strobe.

A single-edge counter needs a window of 4P reference periods to reach this resolution. Counting both edges gives the same resolution in half the time. Jitter between the window and the counted clock makes the sum land on one of two adjacent values, 2m or 2m+1, for a given input frequency. The oscillator frequency resolution is therefore 4 / (4P * Tref).

Top module: `fcnt_dual_edge`

## Requirements
- R1: While reset is asserted and after its release, `count` is 0 and `count_vld` is 0 until the first measurement completes.
- R2: A `start` high at a rising `clk_ref` edge opens a gate of exactly 2P reference cycles. `count_vld` rises at the rising edge 2P+SETTLE+1 edges after that sampling edge (39 with the defaults).
- R3: The reported `count` equals the number of rising plus falling `clk_div` edges inside the window, within one. For a clock of period Tdiv, this is 2 * 2P * Tref / Tdiv, within one.
- R4: Each measurement starts from zero, so a result never includes edges from an earlier window.
- R5: `count_vld` is high for exactly one reference cycle per measurement.
- R6: `count` changes only in a cycle where `count_vld` is high, and otherwise holds the last result.
- R7: `start` pulses that arrive while a measurement is in progress are ignored: no extra window and no extra `count_vld`. No `count_vld` appears while the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; times the gate and owns the result |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each domain |
| clk_div | input | 1 | Divided oscillator clock being measured |
| start | input | 1 | Measurement request, sampled on `clk_ref` |
| count | output | CW+1 | Sum of rising-edge and falling-edge counts from the last window |
| count_vld | output | 1 | One-cycle strobe marking a new `count` |

## Verification
The hardest situation to reach is a window edge whose position relative to the measured clock changes the result. The bench therefore offsets `clk_div` by a fractional amount from the reference grid, so that no edge of either clock coincides. It then sweeps periods of 4, 5, 8 and 10 ns, with half periods that alternate the fractional phase. The exact edge counts are known in advance for each period. A slow measurement following a fast one exposes any counter that is not cleared. A start pulse placed in the middle of the gate shows that a busy measurement cannot be restarted.

// File: rtl/fcnt_pkg.sv
`timescale 1ns/100ps
package fcnt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_CAPT  = 2'd3
  } meas_state_t;
endpackage

// File: rtl/fcnt_rst_sync.sv
`timescale 1ns/100ps
module fcnt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/fcnt_phase_cnt.sv
`timescale 1ns/100ps
module fcnt_phase_cnt #(
  parameter int CW     = 13,
  parameter bit INVERT = 1'b0
) (
  input  logic          clk_div,
  input  logic          arst_n,
  input  logic          gate_ref,
  output logic [CW-1:0] cnt
);
  logic clk_cnt;
  logic srst_n;
  logic gate_m, gate_s, gate_d;
  logic [CW-1:0] cnt_nxt;

  generate
    if (INVERT) begin : g_inv
      assign clk_cnt = ~clk_div;
    end else begin : g_true
      assign clk_cnt = clk_div;
    end
  endgenerate

  fcnt_rst_sync rs_i (.clk(clk_cnt), .arst_n(arst_n), .srst_n(srst_n));

  always_ff @(posedge clk_cnt or negedge srst_n) begin
    if (!srst_n) begin
      gate_m <= 1'b0;
      gate_s <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      gate_m <= gate_ref;
      gate_s <= gate_m;
      gate_d <= gate_s;
    end
  end

  always_comb begin
    cnt_nxt = cnt;
    if (gate_s && !gate_d) cnt_nxt = CW'(1);
    else if (gate_s)       cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk_cnt or negedge srst_n) begin
    if (!srst_n) cnt <= '0;
    else         cnt <= cnt_nxt;
  end
endmodule

// File: rtl/fcnt_gate_ctrl.sv
`timescale 1ns/100ps
module fcnt_gate_ctrl
  import fcnt_pkg::*;
#(
  parameter int P      = 16,
  parameter int SETTLE = 6,
  parameter int CW     = 13
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_pos,
  input  logic [CW-1:0] cnt_neg,
  output logic          gate,
  output logic [CW:0]   count,
  output logic          count_vld
);
  localparam int WIN = 2 * P;
  localparam int TW  = $clog2(WIN + SETTLE + 1);

  meas_state_t state, state_nxt;
  logic [TW-1:0] tmr, tmr_nxt;
  logic [CW-1:0] pos_m, pos_s, neg_m, neg_s;
  logic          smp_en;
  logic          res_en;
  logic [CW:0]   sum;

  always_comb begin
    state_nxt = state;
    tmr_nxt   = tmr;
    case (state)
      ST_IDLE: if (start) begin
        state_nxt = ST_GATE;
        tmr_nxt   = '0;
      end
      ST_GATE: begin
        tmr_nxt = tmr + TW'(1);
        if (tmr == TW'(WIN - 1)) begin
          state_nxt = ST_DRAIN;
          tmr_nxt   = '0;
        end
      end
      ST_DRAIN: begin
        tmr_nxt = tmr + TW'(1);
        if (tmr == TW'(SETTLE - 1)) state_nxt = ST_CAPT;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      state <= state_nxt;
      tmr   <= tmr_nxt;
    end
  end

  assign gate   = (state == ST_GATE);
  assign smp_en = (state == ST_DRAIN);
  assign res_en = (state == ST_CAPT);
  assign sum    = {1'b0, pos_s} + {1'b0, neg_s};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pos_m <= '0;
      pos_s <= '0;
      neg_m <= '0;
      neg_s <= '0;
    end else if (smp_en) begin
      pos_m <= cnt_pos;
      pos_s <= pos_m;
      neg_m <= cnt_neg;
      neg_s <= neg_m;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      count     <= '0;
      count_vld <= 1'b0;
    end else begin
      count_vld <= res_en;
      if (res_en) count <= sum;
    end
  end
endmodule

// File: rtl/fcnt_dual_edge.sv
`timescale 1ns/100ps
module fcnt_dual_edge #(
  parameter int P      = 16,
  parameter int SETTLE = 6,
  parameter int CW     = 13
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        clk_div,
  input  logic        start,
  output logic [CW:0] count,
  output logic        count_vld
);
  logic          ref_rst_n;
  logic          gate_ref;
  logic [CW-1:0] ph_cnt [2];

  fcnt_rst_sync ref_rs_i (.clk(clk_ref), .arst_n(rst_n), .srst_n(ref_rst_n));

  generate
    for (genvar g = 0; g < 2; g++) begin : g_phase
      fcnt_phase_cnt #(.CW(CW), .INVERT(g == 1)) cnt_i (
        .clk_div  (clk_div),
        .arst_n   (rst_n),
        .gate_ref (gate_ref),
        .cnt      (ph_cnt[g])
      );
    end
  endgenerate

  fcnt_gate_ctrl #(.P(P), .SETTLE(SETTLE), .CW(CW)) ctrl_i (
    .clk       (clk_ref),
    .srst_n    (ref_rst_n),
    .start     (start),
    .cnt_pos   (ph_cnt[0]),
    .cnt_neg   (ph_cnt[1]),
    .gate      (gate_ref),
    .count     (count),
    .count_vld (count_vld)
  );
endmodule

// File: rtl/fcnt_chk.sv
`timescale 1ns/100ps
module fcnt_chk #(
  parameter int WIN = 32,
  parameter int CW  = 13
) (
  input logic        clk_ref,
  input logic        rst_n,
  input logic        gate,
  input logic        count_vld,
  input logic [CW:0] count
);
  localparam int HW = $clog2(WIN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (gate) hi_cnt <= hi_cnt + HW'(1);
    else           hi_cnt <= '0;
  end

  a_r2_window_len: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(gate) |-> (hi_cnt == HW'(WIN)));

  a_r5_vld_pulse: assert property (@(posedge clk_ref) disable iff (!rst_n)
    count_vld |=> !count_vld);

  a_r6_count_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !count_vld |-> $stable(count));

  a_r7_no_vld_in_window: assert property (@(posedge clk_ref) disable iff (!rst_n)
    gate |-> !count_vld);
endmodule

bind fcnt_dual_edge fcnt_chk #(.WIN(2 * P), .CW(CW)) chk_i (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .gate      (gate_ref),
  .count_vld (count_vld),
  .count     (count)
);

// File: tb/fcnt_dual_edge_tb_top.sv
`timescale 1ns/100ps
module fcnt_dual_edge_tb_top;
  localparam realtime CLK_PERIOD = 10.0;
  localparam int P      = 16;
  localparam int SETTLE = 6;
  localparam int CW     = 13;
  localparam int WIN    = 2 * P;
  localparam int LAT    = WIN + SETTLE + 1;

  logic          clk_ref;
  logic          rst_n;
  logic          clk_div;
  logic          start;
  logic [CW:0]   count;
  logic          count_vld;
  realtime       div_half;
  int            total;
  int            bad;
  bit            done;

  fcnt_dual_edge #(.P(P), .SETTLE(SETTLE), .CW(CW)) dut_i (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .clk_div   (clk_div),
    .start     (start),
    .count     (count),
    .count_vld (count_vld)
  );

  initial begin
    clk_ref = 1'b0;
    forever #(CLK_PERIOD / 2.0) clk_ref = ~clk_ref;
  end

  initial begin
    clk_div  = 1'b0;
    div_half = 2.0;
    #1.3;
    forever #(div_half) clk_div = ~clk_div;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (5) @(negedge clk_ref);
    check(count == 0, "R1 count in reset", int'(count), 0);
    check(count_vld == 1'b0, "R1 vld in reset", int'(count_vld), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_ref);
    check(count == 0, "R1 count after release", int'(count), 0);
    check(count_vld == 1'b0, "R1 vld after release", int'(count_vld), 0);
  endtask

  task automatic measure(input realtime half, input int exp_cnt, input bit poke, input string tag);
    int early;
    int held;
    int extra;
    div_half = half;
    repeat (4) @(negedge clk_ref);
    start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    early = 0;
    for (int i = 1; i < LAT; i++) begin
      if (poke && i == 5)  start = 1'b1;
      if (poke && i == 20) start = 1'b1;
      @(negedge clk_ref);
      start = 1'b0;
      if (count_vld) early++;
    end
    @(negedge clk_ref);
    check(early == 0, {"R2 no early vld ", tag}, early, 0);
    check(count_vld == 1'b1, {"R2 vld at latency ", tag}, int'(count_vld), 1);
    check((int'(count) >= exp_cnt - 1) && (int'(count) <= exp_cnt + 1),
          {"R3 R4 edge count ", tag}, int'(count), exp_cnt);
    held = int'(count);
    @(negedge clk_ref);
    check(count_vld == 1'b0, {"R5 single pulse ", tag}, int'(count_vld), 0);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_ref);
      if (count_vld) extra++;
      if (int'(count) != held) extra++;
    end
    check(int'(count) == held, {"R6 count held ", tag}, int'(count), held);
    check(extra == 0, {"R7 no extra result ", tag}, extra, 0);
  endtask

  task automatic t_fast();   measure(2.0, 160, 1'b0, "T4");  endtask
  task automatic t_slow();   measure(5.0, 64,  1'b0, "T10"); endtask
  task automatic t_mid();    measure(2.5, 128, 1'b0, "T5");  endtask
  task automatic t_eight();  measure(4.0, 80,  1'b0, "T8");  endtask
  task automatic t_busy();   measure(2.5, 128, 1'b1, "busy"); endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    t_reset();
    t_fast();
    t_slow();
    t_mid();
    t_eight();
    t_busy();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000.0);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule